// File: doc/BRIEF.md
# Inverted DQ-to-Three-Phase Current Converter

This block turns a pair of rotating-frame current commands (a direct and a quadrature component) back into three stationary phase currents that an active compensator can inject. Before it reconstructs anything, it flips the sign of both commands. The resulting phase currents therefore oppose the load current they were derived from.

The reconstruction has two steps. First, the negated vector is rotated by the supplied voltage phase angle to give an alpha/beta pair; this is the inverse rotating-frame transform. Second, the alpha/beta pair is spread onto three phases 120 degrees apart. The rotation is done by a pipelined shift-and-add rotator, and a gain correction is applied after it. Each input strobe yields exactly one output triple, a fixed number of clocks later. Every output is clipped to the signed 14-bit range, so nothing wraps.

Top module: `dq_inv_converter`

## Requirements
- R1: Both commands are sign-inverted before reconstruction. With a phase angle of 0 and a quadrature command of 0, phase A equals the negated direct command within 3 LSB.
- R2: The negated commands d' and q' are rotated by the angle phi: alpha = d'·cos(phi) − q'·sin(phi) and beta = d'·sin(phi) + q'·cos(phi). Each output is within 3 LSB of the exact value.
- R3: Phase A equals alpha. Phases B and C equal −alpha/2 + (√3/2)·beta and −alpha/2 − (√3/2)·beta. When no output is clipped, the three outputs sum to within ±3 LSB of zero.
- R4: Commands and phase outputs are two's-complement 14-bit with 13 fractional bits (code 8192 = 1.0). An output whose exact value exceeds the range is clipped to 8191 or −8192.
- R5: Negating the command code −8192 yields +8191, not −8192.
- R6: The angle is two's-complement 13-bit in radians with 9 fractional bits. The whole range −pi..+pi (codes −1608..+1608) is handled, in all four quadrants.
- R7: Each cycle with `smp_valid` high produces exactly one cycle of `phase_valid`, `ITERS`+3 clocks later. `phase_valid` never rises without a matching strobe. Strobes may arrive back to back.
- R8: The phase outputs hold their values in every cycle in which `phase_valid` is low.
- R9: While `rst` is high, and in the cycle after it, `phase_valid` is low and all three phase outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Strobe marking a new command sample |
| cmd_d | input | 14 | Direct-axis current command, s1.13 |
| cmd_q | input | 14 | Quadrature-axis current command, s1.13 |
| angle | input | 13 | Voltage phase angle in radians, s4.9 |
| phase_valid | output | 1 | One-cycle pulse marking a new output triple |
| phase_a | output | 14 | Compensation current for phase A, s1.13 |
| phase_b | output | 14 | Compensation current for phase B, s1.13 |
| phase_c | output | 14 | Compensation current for phase C, s1.13 |

## Verification
The bench builds the block with its default widths and `ITERS`=14, which puts the expected latency at 17 clocks. At this depth the residual rotation error after the last stage is small enough that a 3 LSB tolerance against exact trigonometry still exposes a wrong sign, a swapped term or a missing gain correction. Directed samples reach the extreme angle codes ±1608, both clipping rails of phase B, and the −8192 command code. Random samples with mixed gaps and back-to-back strobes cover all quadrants and exercise the hold behaviour of the outputs between pulses.

// File: rtl/dqc_pkg.sv
package dqc_pkg;

    // External formats
    localparam int DATA_W    = 14;
    localparam int ANG_W     = 13;
    localparam int ANG_FRAC  = 9;

    // Internal vector format: extra fraction and integer headroom
    localparam int GUARD_F   = 3;
    localparam int GUARD_I   = 3;
    localparam int X_W       = DATA_W + GUARD_F + GUARD_I;
    localparam int X_FRAC    = DATA_W - 1 + GUARD_F;

    // Internal angle format
    localparam int Z_GUARD   = 6;
    localparam int Z_W       = ANG_W + Z_GUARD;
    localparam int Z_FRAC    = ANG_FRAC + Z_GUARD;

    // Fixed-point constant precision
    localparam int KQ        = 15;
    localparam int SAT_W     = X_W + 1;

    localparam real PI_R     = 3.14159265358979323846;

    localparam logic signed [DATA_W-1:0] DMAX = DATA_W'(2**(DATA_W-1) - 1);
    localparam logic signed [DATA_W-1:0] DMIN = DATA_W'(-(2**(DATA_W-1)));

    localparam logic signed [Z_W-1:0] PI_Z      = Z_W'($rtoi(PI_R * (2.0**Z_FRAC) + 0.5));
    localparam logic signed [Z_W-1:0] HALF_PI_Z = Z_W'($rtoi(PI_R * (2.0**(Z_FRAC-1)) + 0.5));
    localparam logic signed [KQ+1:0]  S3H       = (KQ+2)'($rtoi($sqrt(3.0) * (2.0**(KQ-1)) + 0.5));

    typedef struct packed {
        logic                 vld;
        logic [X_W-1:0]       x;
        logic [X_W-1:0]       y;
        logic [Z_W-1:0]       z;
    } rot_t;

    // Elementary rotation angle atan(2^-i) in internal angle units
    function automatic int atan_code(input int i);
        real t;
        t = 1.0;
        for (int j = 0; j < i; j++) t = t / 2.0;
        return $rtoi($atan(t) * (2.0**Z_FRAC) + 0.5);
    endfunction

    // Reciprocal of the accumulated rotator gain after n stages
    function automatic int kinv_code(input int n);
        real k;
        real t;
        k = 1.0;
        t = 1.0;
        for (int j = 0; j < n; j++) begin
            k = k * $sqrt(1.0 + t * t);
            t = t / 2.0;
        end
        return $rtoi((2.0**KQ) / k + 0.5);
    endfunction

    // Negation that maps the most negative code to the most positive one
    function automatic logic signed [DATA_W-1:0] neg_sat(input logic signed [DATA_W-1:0] v);
        return (v == DMIN) ? DMAX : -v;
    endfunction

    // Clip a wide value to the output range
    function automatic logic signed [DATA_W-1:0] clip(input logic signed [SAT_W-1:0] v);
        if (v > SAT_W'(DMAX))      return DMAX;
        else if (v < SAT_W'(DMIN)) return DMIN;
        else                       return v[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/dqc_prerot.sv
module dqc_prerot
    import dqc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_valid,
    input  logic signed [DATA_W-1:0] cmd_d,
    input  logic signed [DATA_W-1:0] cmd_q,
    input  logic signed [ANG_W-1:0]  angle,
    output rot_t                     vec_o
);

    logic signed [DATA_W-1:0] d_neg, q_neg;
    logic signed [X_W-1:0]    x_ext, y_ext;
    logic signed [Z_W-1:0]    z_ext;
    rot_t                     nxt;

    always_comb begin
        d_neg = neg_sat(cmd_d);
        q_neg = neg_sat(cmd_q);
        x_ext = X_W'(d_neg) <<< GUARD_F;
        y_ext = X_W'(q_neg) <<< GUARD_F;
        z_ext = {angle, {Z_GUARD{1'b0}}};

        nxt.vld = smp_valid;
        // Fold the angle into the rotator's convergence range by a half turn
        if (z_ext > HALF_PI_Z) begin
            nxt.x = -x_ext;
            nxt.y = -y_ext;
            nxt.z = z_ext - PI_Z;
        end else if (z_ext < -HALF_PI_Z) begin
            nxt.x = -x_ext;
            nxt.y = -y_ext;
            nxt.z = z_ext + PI_Z;
        end else begin
            nxt.x = x_ext;
            nxt.y = y_ext;
            nxt.z = z_ext;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) vec_o <= '0;
        else     vec_o <= nxt;
    end

endmodule

// File: rtl/dqc_rot_stage.sv
module dqc_rot_stage
    import dqc_pkg::*;
#(
    parameter int SHIFT = 0
)(
    input  logic clk,
    input  logic rst,
    input  rot_t vec_i,
    output rot_t vec_o
);

    localparam logic signed [Z_W-1:0] STEP = Z_W'(atan_code(SHIFT));

    logic signed [X_W-1:0] xi, yi, xs, ys;
    logic signed [Z_W-1:0] zi;
    rot_t                  nxt;

    always_comb begin
        xi = vec_i.x;
        yi = vec_i.y;
        zi = vec_i.z;
        xs = xi >>> SHIFT;
        ys = yi >>> SHIFT;
        nxt.vld = vec_i.vld;
        if (!zi[Z_W-1]) begin
            nxt.x = xi - ys;
            nxt.y = yi + xs;
            nxt.z = zi - STEP;
        end else begin
            nxt.x = xi + ys;
            nxt.y = yi - xs;
            nxt.z = zi + STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) vec_o <= '0;
        else     vec_o <= nxt;
    end

endmodule

// File: rtl/dqc_clarke.sv
module dqc_clarke
    import dqc_pkg::*;
#(
    parameter int ITERS = 14
)(
    input  logic                     clk,
    input  logic                     rst,
    input  rot_t                     vec_i,
    output logic                     phase_valid,
    output logic signed [DATA_W-1:0] phase_a,
    output logic signed [DATA_W-1:0] phase_b,
    output logic signed [DATA_W-1:0] phase_c
);

    localparam logic signed [KQ+1:0] KINV = (KQ+2)'(kinv_code(ITERS));
    localparam int RSH = X_FRAC - (DATA_W - 1);
    localparam logic signed [SAT_W-1:0] RND = SAT_W'(2**(RSH-1));

    // Stage 1: gain correction
    logic signed [X_W-1:0]      xi, yi;
    logic signed [X_W+KQ+1:0]   pa, pb;
    logic signed [X_W-1:0]      alpha, beta;
    logic                       g_vld;

    always_comb begin
        xi = vec_i.x;
        yi = vec_i.y;
        pa = xi * KINV;
        pb = yi * KINV;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            g_vld <= 1'b0;
            alpha <= '0;
            beta  <= '0;
        end else begin
            g_vld <= vec_i.vld;
            alpha <= X_W'(pa >>> KQ);
            beta  <= X_W'(pb >>> KQ);
        end
    end

    // Stage 2: spread onto three phases, round and clip
    logic signed [X_W+KQ+1:0]  pr;
    logic signed [SAT_W-1:0]   half_a, sb, wa, wb, wc;

    always_comb begin
        pr     = beta * S3H;
        half_a = SAT_W'(alpha >>> 1);
        sb     = SAT_W'(pr >>> KQ);
        wa     = (SAT_W'(alpha) + RND) >>> RSH;
        wb     = (sb - half_a + RND) >>> RSH;
        wc     = (-sb - half_a + RND) >>> RSH;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_valid <= 1'b0;
            phase_a     <= '0;
            phase_b     <= '0;
            phase_c     <= '0;
        end else begin
            phase_valid <= g_vld;
            if (g_vld) begin
                phase_a <= clip(wa);
                phase_b <= clip(wb);
                phase_c <= clip(wc);
            end
        end
    end

endmodule

// File: rtl/dq_inv_converter.sv
module dq_inv_converter
    import dqc_pkg::*;
#(
    parameter int ITERS = 14
)(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_valid,
    input  logic signed [DATA_W-1:0] cmd_d,
    input  logic signed [DATA_W-1:0] cmd_q,
    input  logic signed [ANG_W-1:0]  angle,
    output logic                     phase_valid,
    output logic signed [DATA_W-1:0] phase_a,
    output logic signed [DATA_W-1:0] phase_b,
    output logic signed [DATA_W-1:0] phase_c
);

    localparam int LAT = ITERS + 3;

    rot_t pipe [0:ITERS];

    dqc_prerot u_prerot (
        .clk       (clk),
        .rst       (rst),
        .smp_valid (smp_valid),
        .cmd_d     (cmd_d),
        .cmd_q     (cmd_q),
        .angle     (angle),
        .vec_o     (pipe[0])
    );

    for (genvar s = 0; s < ITERS; s++) begin : g_rot
        dqc_rot_stage #(.SHIFT(s)) u_stage (
            .clk   (clk),
            .rst   (rst),
            .vec_i (pipe[s]),
            .vec_o (pipe[s+1])
        );
    end

    dqc_clarke #(.ITERS(ITERS)) u_clarke (
        .clk         (clk),
        .rst         (rst),
        .vec_i       (pipe[ITERS]),
        .phase_valid (phase_valid),
        .phase_a     (phase_a),
        .phase_b     (phase_b),
        .phase_c     (phase_c)
    );

endmodule

// File: rtl/dqc_chk.sv
module dqc_chk #(
    parameter int LAT = 17
)(
    input logic               clk,
    input logic               rst,
    input logic               smp_valid,
    input logic               phase_valid,
    input logic signed [13:0] phase_a,
    input logic signed [13:0] phase_b,
    input logic signed [13:0] phase_c
);

    logic [LAT-1:0]     vpipe;
    logic signed [15:0] total;
    logic               any_rail;

    always_ff @(posedge clk) begin
        if (rst) vpipe <= '0;
        else     vpipe <= {vpipe[LAT-2:0], smp_valid};
    end

    always_comb begin
        total    = 16'(phase_a) + 16'(phase_b) + 16'(phase_c);
        any_rail = (phase_a == 14'sd8191) || (phase_a == -14'sd8192) ||
                   (phase_b == 14'sd8191) || (phase_b == -14'sd8192) ||
                   (phase_c == 14'sd8191) || (phase_c == -14'sd8192);
    end

    // R7
    latency_match_chk: assert property (@(posedge clk) disable iff (rst)
        phase_valid == vpipe[LAT-1]);

    // R8
    hold_between_chk: assert property (@(posedge clk) disable iff (rst)
        !phase_valid |-> ($stable(phase_a) && $stable(phase_b) && $stable(phase_c)));

    // R3
    balanced_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_valid && !any_rail) |-> (total <= 16'sd3 && total >= -16'sd3));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!phase_valid && phase_a == 14'sd0 && phase_b == 14'sd0 && phase_c == 14'sd0));

endmodule

bind dq_inv_converter dqc_chk #(.LAT(LAT)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .smp_valid   (smp_valid),
    .phase_valid (phase_valid),
    .phase_a     (phase_a),
    .phase_b     (phase_b),
    .phase_c     (phase_c)
);

// File: tb/dq_inv_converter_bench.sv
module dq_inv_converter_bench;

    localparam int ITERS = 14;
    localparam int LAT   = ITERS + 3;
    localparam int TOL   = 3;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               smp_valid = 1'b0;
    logic signed [13:0] cmd_d = '0;
    logic signed [13:0] cmd_q = '0;
    logic signed [12:0] angle = '0;
    logic               phase_valid;
    logic signed [13:0] phase_a, phase_b, phase_c;

    always #2 clk = ~clk;

    dq_inv_converter #(.ITERS(ITERS)) u_dq_inv_converter (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .cmd_d(cmd_d), .cmd_q(cmd_q), .angle(angle),
        .phase_valid(phase_valid),
        .phase_a(phase_a), .phase_b(phase_b), .phase_c(phase_c)
    );

    typedef struct {
        int    a;
        int    b;
        int    c;
        int    cyc;
        string req;
    } exp_t;

    exp_t  expq[$];
    int    checks = 0;
    int    failures = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    int    last_a = 0, last_b = 0, last_c = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int to_code(input real v);
        int r;
        r = (v >= 0.0) ? $rtoi(v * 8192.0 + 0.5) : -$rtoi(-v * 8192.0 + 0.5);
        if (r > 8191)  r = 8191;
        if (r < -8192) r = -8192;
        return r;
    endfunction

    function automatic real neg_real(input int c);
        return (c == -8192) ? 8191.0 / 8192.0 : -c / 8192.0;
    endfunction

    task automatic check(input string req, input string what, input int got, input int exp, input int tol);
        int diff;
        checks++;
        diff = got - exp;
        if (diff < 0) diff = -diff;
        if (diff > tol) begin
            failures++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic send(input int d, input int q, input int p, input string req);
        exp_t e;
        real dn, qn, ph, al, be;
        @(negedge clk);
        cmd_d = 14'(d);
        cmd_q = 14'(q);
        angle = 13'(p);
        smp_valid = 1'b1;
        dn = neg_real(d);
        qn = neg_real(q);
        ph = p / 512.0;
        al = dn * $cos(ph) - qn * $sin(ph);
        be = dn * $sin(ph) + qn * $cos(ph);
        e.a = to_code(al);
        e.b = to_code(-al / 2.0 + $sqrt(3.0) / 2.0 * be);
        e.c = to_code(-al / 2.0 - $sqrt(3.0) / 2.0 * be);
        e.cyc = cyc + LAT;
        e.req = req;
        expq.push_back(e);
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    // Output monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (phase_valid) begin
                if (expq.size() == 0) begin
                    checks++;
                    failures++;
                    $display("FAIL R7 spurious pulse: got 1 expected 0");
                end else begin
                    exp_t e;
                    e = expq.pop_front();
                    check("R7", "latency cycle", cyc, e.cyc, 0);
                    check(e.req, "phase A", int'(phase_a), e.a, TOL);
                    check(e.req, "phase B", int'(phase_b), e.b, TOL);
                    check(e.req, "phase C", int'(phase_c), e.c, TOL);
                end
                last_a = int'(phase_a);
                last_b = int'(phase_b);
                last_c = int'(phase_c);
            end else begin
                // R8: hold while no pulse
                check("R8", "hold A", int'(phase_a), last_a, 0);
                check("R8", "hold B", int'(phase_b), last_b, 0);
                check("R8", "hold C", int'(phase_c), last_c, 0);
            end
        end
    end

    task automatic drain();
        for (int k = 0; k < 4 * LAT && expq.size() != 0; k++) @(negedge clk);
        checks++;
        if (expq.size() != 0) begin
            failures++;
            $display("FAIL R7 missing pulses: got %0d pending expected 0", expq.size());
        end
    endtask

    initial begin
        #(4 * 150000);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed;
        seed = 32'h5EED_D00C;
        void'($urandom(seed));
        repeat (5) @(negedge clk);
        // R9: reset state
        check("R9", "valid in reset", int'(phase_valid), 0, 0);
        check("R9", "A in reset", int'(phase_a), 0, 0);
        check("R9", "B in reset", int'(phase_b), 0, 0);
        check("R9", "C in reset", int'(phase_c), 0, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R9", "valid after reset", int'(phase_valid), 0, 0);

        // R1: zero angle, D only: A = -D
        send(4096, 0, 0, "R1");
        send(-2000, 0, 0, "R1");
        // R2: quarter-turn rotation, Q only
        send(0, 4096, 804, "R2");
        send(3000, -1500, -500, "R2");
        // R3: general split onto three phases
        send(2500, 3500, 300, "R3");
        // R5: most negative command codes
        send(-8192, 0, 0, "R5");
        send(0, -8192, 0, "R5");
        // R4: phase B driven past both rails
        send(-8192, -8192, 670, "R4");
        send(-8192, -8192, -938, "R4");
        // R6: angle range extremes and quadrant folds
        send(4000, 1000, 1608, "R6");
        send(4000, 1000, -1608, "R6");
        send(-3000, 2000, 900, "R6");
        send(-3000, 2000, -900, "R6");
        drain();

        // R7: back-to-back strobes
        @(negedge clk);
        for (int k = 0; k < 6; k++) begin
            exp_t e;
            real dn, qn, ph, al, be;
            int d, q, p;
            d = 500 * k - 1200;
            q = 700 - 300 * k;
            p = 250 * k - 700;
            cmd_d = 14'(d); cmd_q = 14'(q); angle = 13'(p); smp_valid = 1'b1;
            dn = neg_real(d); qn = neg_real(q); ph = p / 512.0;
            al = dn * $cos(ph) - qn * $sin(ph);
            be = dn * $sin(ph) + qn * $cos(ph);
            e.a = to_code(al);
            e.b = to_code(-al / 2.0 + $sqrt(3.0) / 2.0 * be);
            e.c = to_code(-al / 2.0 - $sqrt(3.0) / 2.0 * be);
            e.cyc = cyc + LAT;
            e.req = "R7";
            expq.push_back(e);
            @(negedge clk);
        end
        smp_valid = 1'b0;
        drain();

        // R2/R3/R6 random samples with random gaps
        for (int n = 0; n < 300; n++) begin
            int d, q, p, gap;
            d = int'($urandom_range(16383)) - 8192;
            q = int'($urandom_range(16383)) - 8192;
            p = int'($urandom_range(3216)) - 1608;
            send(d, q, p, "R2");
            gap = int'($urandom_range(3));
            repeat (gap) @(negedge clk);
        end
        drain();

        repeat (5) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule